// File: doc/BRIEF.md
# Three-Phase Inverter Switch Model

This block is a fixed-point behavioural stand-in for a two-level three-phase inverter. It is used where a motor controller is tested against emulated power hardware. The block accepts six gate bits, one top and one bottom switch for each of three legs. It also takes a DC-link voltage and the phase currents that a load model feeds back. From these it returns the three line-to-line voltages the controller would see. Conduction losses are folded into the result. A switch that is on drops its current times the switch resistance. With both switches of a leg open, the leg is clamped by whichever freewheeling diode the current direction selects. That diode adds its threshold and its own resistive drop.

Every gate pattern is legal. There is no interlock, so a leg with both switches closed gets a defined pole voltage and is not blocked. The phase-c current can be rebuilt from the other two, because the three currents sum to zero. One sample may enter per clock. Each sample leaves after a fixed three-cycle pipeline, and a valid flag marks it.

Top module: `inv3_switch_model`

## Requirements
- R1: Gate bit 0 is leg a top, bit 1 leg a bottom, bit 2 leg b top, bit 3 leg b bottom, bit 4 leg c top, bit 5 leg c bottom. With only the top switch on, the leg pole voltage is Udc − floor(i·RSW/2^22). With only the bottom switch on, it is −floor(i·RSW/2^22). RSW is the switch resistance in units of 2^-20 ohm (default 10486, about 0.01 ohm).
- R2: With both switches of a leg off, the pole voltage depends on the sign of the phase current. For i > 0 it is −(VTH + floor(i·RD/2^22)). For i < 0 it is Udc + VTH + floor(|i|·RD/2^22). For i = 0 it is 0. RD defaults to 1049 (about 0.001 ohm, units 2^-20 ohm) and VTH to 52429 (about 0.8 V, units 2^-16 V).
- R3: A leg with both switches on has pole voltage 0, and the output stays defined. With all six gates on, all three outputs are 0.
- R4: The outputs are line-to-line voltages: u_ab = pa − pb, u_bc = pb − pc, u_ca = pc − pa. Currents are signed 27-bit values with 18 fractional bits. Udc and all outputs are signed 27-bit values with 16 fractional bits.
- R5: When all phase currents are zero, each switched leg gives the ideal voltage: Udc with the top switch on, 0 with the bottom switch on.
- R6: Each line-to-line result saturates to the range [−2^26, 2^26−1] of the output format.
- R7: A sample taken with in_valid high at clock edge k appears on the outputs, with out_valid high, after edge k+3. out_valid is in_valid delayed by three cycles.
- R8: While out_valid is low, the three outputs hold their previous values.
- R9: With DERIVE_IC = 1 (the default), the phase-c current is −(i_a + i_b) and the i_c input has no effect on the outputs.
- R10: While rst_n is low at a clock edge, out_valid and all three outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| gate | input | 6 | Switch commands, order as in R1 |
| udc | input | 27 | DC-link voltage, signed, 16 fractional bits |
| i_a | input | 27 | Phase a current, signed, 18 fractional bits |
| i_b | input | 27 | Phase b current, signed, 18 fractional bits |
| i_c | input | 27 | Phase c current, used only when DERIVE_IC = 0 |
| out_valid | output | 1 | Output sample qualifier |
| u_ab | output | 27 | Line voltage a to b, signed, 16 fractional bits |
| u_bc | output | 27 | Line voltage b to c, signed, 16 fractional bits |
| u_ca | output | 27 | Line voltage c to a, signed, 16 fractional bits |

## Verification
The bench builds the block with its default parameters. The widths are 27 bits, the loss constants are about 0.01 ohm, 0.001 ohm and 0.8 V, and DERIVE_IC = 1. At these values a DC link near the top of the output range, together with a large reverse current through an open leg, drives the line voltages past both rails, so the saturation paths are exercised. Because the phase-c current is derived, a random i_c on every sample checks that this input is ignored. Fractional current magnitudes reach the floor rounding of the drop terms on both signs.

// File: rtl/inv3_pkg.sv
// Package: shared types for the three-phase inverter switch model.
// Assumes the leg state is formed as {bottom, top} gate bits.
package inv3_pkg;

    // Conduction state of one half bridge, encoded {bottom, top}
    typedef enum logic [1:0] {
        LEG_OPEN  = 2'b00,
        LEG_HIGH  = 2'b01,
        LEG_LOW   = 2'b10,
        LEG_SHORT = 2'b11
    } leg_state_e;

    // Build the leg state from the two gate bits of one leg
    function automatic leg_state_e leg_decode(input logic top, input logic bot);
        return leg_state_e'({bot, top});
    endfunction

endpackage

// File: rtl/inv3_leg_pole.sv
// Module: inv3_leg_pole
// Computes the registered pole voltage of one half bridge from its gate pair,
// the DC-link voltage and the phase current. The switch and diode drops use
// floor rounding in output LSBs. A closed-closed leg yields 0.
// Assumes: the current carries CFRAC fractional bits, the resistances carry
// RFRAC fractional bits and the voltages carry VFRAC fractional bits.
module inv3_leg_pole
    import inv3_pkg::*;
#(
    parameter int CW     = 29,
    parameter int VW     = 27,
    parameter int PW     = 29,
    parameter int RW     = 16,
    parameter int SHIFT  = 22,
    parameter int RON_SW = 10486,
    parameter int RON_D  = 1049,
    parameter int VTH_D  = 52429
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 top,
    input  logic                 bot,
    input  logic signed [VW-1:0] udc,
    input  logic signed [CW-1:0] cur,
    output logic signed [PW-1:0] pole
);

    localparam int MW = CW + RW + 2;

    logic signed [MW-1:0] cur_x;
    logic signed [MW-1:0] mag_x;
    logic signed [MW-1:0] prod_sw;
    logic signed [MW-1:0] prod_d;
    logic signed [PW-1:0] drop_sw;
    logic signed [PW-1:0] drop_d;
    logic signed [PW-1:0] udc_p;
    logic signed [PW-1:0] vth_p;
    logic signed [PW-1:0] pole_n;
    leg_state_e           state;

    // Scale the current by the switch and diode resistances
    always_comb begin
        cur_x   = MW'(cur);
        mag_x   = (cur_x < 0) ? -cur_x : cur_x;
        prod_sw = cur_x * MW'(RON_SW);
        prod_d  = mag_x * MW'(RON_D);
        drop_sw = PW'(prod_sw >>> SHIFT);
        drop_d  = PW'(prod_d >>> SHIFT);
        udc_p   = PW'(udc);
        vth_p   = PW'(VTH_D);
    end

    // Select the pole voltage for the present conduction state
    always_comb begin
        state = leg_decode(top, bot);
        case (state)
            LEG_HIGH:  pole_n = udc_p - drop_sw;
            LEG_LOW:   pole_n = -drop_sw;
            LEG_SHORT: pole_n = '0;
            default: begin
                if (cur_x > 0)      pole_n = -(vth_p + drop_d);
                else if (cur_x < 0) pole_n = udc_p + vth_p + drop_d;
                else                pole_n = '0;
            end
        endcase
    end

    // Register the pole voltage when the stage holds a valid sample
    always_ff @(posedge clk) begin
        if (!rst_n)  pole <= '0;
        else if (en) pole <= pole_n;
    end

endmodule

// File: rtl/inv3_line_diff.sv
// Module: inv3_line_diff
// Forms the three line-to-line differences of the pole voltages, saturates
// each to a VW-bit signed range and registers them. The outputs hold while
// en is low. Assumes PW >= VW.
module inv3_line_diff #(
    parameter int PW = 29,
    parameter int VW = 27
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [PW-1:0] pole [3],
    output logic signed [VW-1:0] line [3]
);

    localparam int DW = PW + 1;
    localparam logic signed [DW-1:0] VMAX = DW'((64'sd1 <<< (VW - 1)) - 1);
    localparam logic signed [DW-1:0] VMIN = -DW'(64'sd1 <<< (VW - 1));

    // Clamp a wide difference into the output range
    function automatic logic signed [VW-1:0] clamp(input logic signed [DW-1:0] d);
        if (d > VMAX)      return VW'(VMAX);
        else if (d < VMIN) return VW'(VMIN);
        else               return VW'(d);
    endfunction

    for (genvar k = 0; k < 3; k++) begin : g_pair
        localparam int NXT = (k + 1) % 3;
        logic signed [DW-1:0] diff;

        // Difference of this pole against the next one in rotation
        always_comb diff = DW'(pole[k]) - DW'(pole[NXT]);

        // Register the saturated line voltage on a valid sample
        always_ff @(posedge clk) begin
            if (!rst_n)  line[k] <= '0;
            else if (en) line[k] <= clamp(diff);
        end
    end

endmodule

// File: rtl/inv3_switch_model.sv
// Module: inv3_switch_model (top)
// Three-stage model of a two-level three-phase inverter: input capture with
// the optional phase-c derivation, per-leg pole voltages with conduction
// drops, then line-to-line differencing with saturation.
// Assumes one sample per clock and no gate interlock; every pattern is legal.
module inv3_switch_model #(
    parameter int IW        = 27,
    parameter int VW        = 27,
    parameter int IFRAC     = 18,
    parameter int VFRAC     = 16,
    parameter int RFRAC     = 20,
    parameter int RW        = 16,
    parameter int RON_SW    = 10486,
    parameter int RON_D     = 1049,
    parameter int VTH_D     = 52429,
    parameter int DERIVE_IC = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [5:0]           gate,
    input  logic signed [VW-1:0] udc,
    input  logic signed [IW-1:0] i_a,
    input  logic signed [IW-1:0] i_b,
    input  logic signed [IW-1:0] i_c,
    output logic                 out_valid,
    output logic signed [VW-1:0] u_ab,
    output logic signed [VW-1:0] u_bc,
    output logic signed [VW-1:0] u_ca
);

    localparam int CW    = IW + 2;
    localparam int PW    = VW + 2;
    localparam int SHIFT = IFRAC + RFRAC - VFRAC;

    logic                 v1, v2, v3;
    logic [5:0]           gate_q;
    logic signed [VW-1:0] udc_q;
    logic signed [CW-1:0] cur_n [3];
    logic signed [CW-1:0] cur_q [3];
    logic signed [PW-1:0] pole  [3];
    logic signed [VW-1:0] line  [3];

    // Widen the currents and rebuild phase c when configured to do so
    always_comb begin
        cur_n[0] = CW'(i_a);
        cur_n[1] = CW'(i_b);
        cur_n[2] = (DERIVE_IC != 0) ? -(CW'(i_a) + CW'(i_b)) : CW'(i_c);
    end

    // Stage 1: capture gates, DC link and currents of a valid sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
            udc_q  <= '0;
            for (int k = 0; k < 3; k++) cur_q[k] <= '0;
        end else if (in_valid) begin
            gate_q <= gate;
            udc_q  <= udc;
            for (int k = 0; k < 3; k++) cur_q[k] <= cur_n[k];
        end
    end

    // Valid flag travelling alongside the three data stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            v3 <= 1'b0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            v3 <= v2;
        end
    end

    // Stage 2: one pole-voltage unit per leg
    for (genvar k = 0; k < 3; k++) begin : g_leg
        inv3_leg_pole #(
            .CW(CW), .VW(VW), .PW(PW), .RW(RW), .SHIFT(SHIFT),
            .RON_SW(RON_SW), .RON_D(RON_D), .VTH_D(VTH_D)
        ) u_leg (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (v1),
            .top  (gate_q[2*k]),
            .bot  (gate_q[2*k+1]),
            .udc  (udc_q),
            .cur  (cur_q[k]),
            .pole (pole[k])
        );
    end

    // Stage 3: line-to-line differences with saturation
    inv3_line_diff #(.PW(PW), .VW(VW)) u_diff (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (v2),
        .pole (pole),
        .line (line)
    );

    assign out_valid = v3;
    assign u_ab      = line[0];
    assign u_bc      = line[1];
    assign u_ca      = line[2];

endmodule

// File: rtl/inv3_switch_model_chk.sv
// Module: inv3_switch_model_chk
// Port-level properties of the inverter switch model, bound to the top.
// Assumes the default three-stage latency.
module inv3_switch_model_chk #(
    parameter int VW = 27
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [5:0]           gate,
    input logic                 out_valid,
    input logic signed [VW-1:0] u_ab,
    input logic signed [VW-1:0] u_bc,
    input logic signed [VW-1:0] u_ca
);

    localparam logic signed [VW-1:0] RAIL_HI = {1'b0, {(VW-1){1'b1}}};
    localparam logic signed [VW-1:0] RAIL_LO = {1'b1, {(VW-1){1'b0}}};

    logic [1:0]         since_rst;
    logic signed [VW+1:0] sum3;
    logic               any_rail;

    // Count clock edges since reset release, saturating at three
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // Sum of the line voltages and a flag for a clipped output
    always_comb begin
        sum3     = (VW+2)'(u_ab) + (VW+2)'(u_bc) + (VW+2)'(u_ca);
        any_rail = (u_ab == RAIL_HI) || (u_ab == RAIL_LO) ||
                   (u_bc == RAIL_HI) || (u_bc == RAIL_LO) ||
                   (u_ca == RAIL_HI) || (u_ca == RAIL_LO);
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst != 2'd0) && !out_valid) |->
            ($stable(u_ab) && $stable(u_bc) && $stable(u_ca))); // R8

    AST_LINE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !any_rail) |-> (sum3 == '0)); // R4

    AST_SHOOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 2'd3) && $past(in_valid, 3) && ($past(gate, 3) == 6'h3F))
            |-> (u_ab == '0 && u_bc == '0 && u_ca == '0)); // R3

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd1) |->
            (!out_valid && u_ab == '0 && u_bc == '0 && u_ca == '0)); // R10

endmodule

bind inv3_switch_model inv3_switch_model_chk #(.VW(VW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .gate     (gate),
    .out_valid(out_valid),
    .u_ab     (u_ab),
    .u_bc     (u_bc),
    .u_ca     (u_ca)
);

// File: tb/inv3_switch_model_tb.sv
// Bench: behavioural reference with a queue of expected samples, compared
// with the outputs on every falling clock edge.
module inv3_switch_model_tb;

    localparam int  CLK_PERIOD = 10;
    localparam longint RSW = 10486;
    localparam longint RD  = 1049;
    localparam longint VTH = 52429;
    localparam longint VMAX = (64'sd1 <<< 26) - 1;
    localparam longint VMIN = -(64'sd1 <<< 26);

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic [5:0]         gate;
    logic signed [26:0] udc, i_a, i_b, i_c;
    logic               out_valid;
    logic signed [26:0] u_ab, u_bc, u_ca;

    typedef struct {
        bit     v;
        longint ab, bc, ca;
        string  tag;
    } exp_t;

    exp_t   pipe[$];
    longint hold_ab, hold_bc, hold_ca;
    int     n_chk  = 0;
    int     n_fail = 0;
    bit     done   = 0;

    inv3_switch_model u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .gate(gate),
        .udc(udc), .i_a(i_a), .i_b(i_b), .i_c(i_c),
        .out_valid(out_valid), .u_ab(u_ab), .u_bc(u_bc), .u_ca(u_ca)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint ref_pole(bit t, bit b, longint u, longint i);
        if (t && b) return 0;
        if (t)      return u - ((i * RSW) >>> 22);
        if (b)      return -((i * RSW) >>> 22);
        if (i > 0)  return -(VTH + ((i * RD) >>> 22));
        if (i < 0)  return u + VTH + (((-i) * RD) >>> 22);
        return 0;
    endfunction

    function automatic longint sat(longint d);
        if (d > VMAX) return VMAX;
        if (d < VMIN) return VMIN;
        return d;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Compare the outputs with the oldest expected sample
    task automatic compare_out();
        exp_t e;
        if (pipe.size() == 3) begin
            e = pipe.pop_front();
            check(out_valid == e.v, "R7", longint'(out_valid), longint'(e.v));
            if (e.v) begin
                hold_ab = e.ab; hold_bc = e.bc; hold_ca = e.ca;
            end
            check(longint'(u_ab) == hold_ab, e.v ? e.tag : "R8", longint'(u_ab), hold_ab);
            check(longint'(u_bc) == hold_bc, e.v ? e.tag : "R8", longint'(u_bc), hold_bc);
            check(longint'(u_ca) == hold_ca, e.v ? e.tag : "R8", longint'(u_ca), hold_ca);
        end
    endtask

    // One cycle: check outputs, drive a new sample, queue its expectation
    task automatic step(bit v, logic [5:0] g, longint u, longint ia, longint ib,
                        longint ic, string tag);
        exp_t   e;
        longint a, b, c, pa, pb, pc, uu;
        @(negedge clk);
        compare_out();
        in_valid = v; gate = g;
        udc = 27'(u); i_a = 27'(ia); i_b = 27'(ib); i_c = 27'(ic);
        uu = longint'(udc); a = longint'(i_a); b = longint'(i_b);
        c  = -(a + b);  // R9: phase c rebuilt from a and b
        pa = ref_pole(g[0], g[1], uu, a);
        pb = ref_pole(g[2], g[3], uu, b);
        pc = ref_pole(g[4], g[5], uu, c);
        e.v = v; e.tag = tag;
        e.ab = sat(pa - pb); e.bc = sat(pb - pc); e.ca = sat(pc - pa);
        pipe.push_back(e);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R10", longint'(out_valid), 0);
        check(u_ab == 0 && u_bc == 0 && u_ca == 0, "R10", longint'(u_ab), 0);
        pipe.delete();
        hold_ab = 0; hold_bc = 0; hold_ca = 0;
        rst_n = 1'b1;
        begin
            exp_t e;
            e.v = 0; e.ab = 0; e.bc = 0; e.ca = 0; e.tag = "R10";
            pipe.push_back(e);
        end
    endtask

    function automatic longint amps(int a); return longint'(a) <<< 18; endfunction
    function automatic longint volts(int v); return longint'(v) <<< 16; endfunction

    initial begin
        in_valid = 0; gate = 0; udc = 0; i_a = 0; i_b = 0; i_c = 0;
        do_reset();

        // R5 and R1: ideal switching with zero current
        step(1, 6'b101001, volts(560), 0, 0, 0, "R5");
        step(1, 6'b011010, volts(560), 0, 0, 0, "R5");
        step(1, 6'b100101, volts(300), 0, 0, 0, "R5");
        // R1: switched legs with currents
        step(1, 6'b101001, volts(560), amps(10), amps(10), amps(10), "R1");
        step(1, 6'b010110, volts(400), -amps(37) - 12345, amps(5) + 777, 0, "R1");
        // R2: open legs for positive, negative and zero currents
        step(1, 6'b000000, volts(500), amps(20), -amps(20), 0, "R2");
        step(1, 6'b000000, volts(500), -amps(3) - 1, 0, 0, "R2");
        step(1, 6'b000000, volts(500), 0, 0, 0, "R2");
        step(1, 6'b100100, volts(500), amps(100) + 3, -amps(40) - 9, 0, "R2");
        // R3: closed-closed legs
        step(1, 6'b111111, volts(600), amps(50), amps(7), 0, "R3");
        step(1, 6'b011011, volts(600), amps(50), -amps(7), 0, "R3");
        // R9: random i_c ignored
        for (int k = 0; k < 8; k++)
            step(1, 6'b011001, volts(450), amps(12), -amps(30), $urandom, "R9");
        // R6: saturation at both rails
        step(1, 6'b001000, VMAX, -amps(100), amps(50), 0, "R6");
        step(1, 6'b000010, VMAX, amps(50), -amps(100), 0, "R6");
        step(1, 6'b010000, VMAX, amps(60), amps(60), 0, "R6");
        // R8: idle cycles with changing inputs
        for (int k = 0; k < 6; k++)
            step(0, 6'(k * 11), volts(100 + k), amps(k), -amps(k), 0, "R8");
        // R4: random mix
        for (int k = 0; k < 3000; k++) begin
            logic [26:0] r1, r2, r3;
            r1 = 27'($urandom); r2 = 27'($urandom); r3 = 27'($urandom);
            step(($urandom % 5) != 0, 6'($urandom), longint'({1'b0, r3[25:0]}),
                 longint'($signed(r1)), longint'($signed(r2)), $urandom, "R4");
        end
        // R10: reset in the middle of traffic
        do_reset();
        step(1, 6'b101001, volts(200), amps(1), amps(2), 0, "R4");
        step(0, 6'b000000, 0, 0, 0, 0, "R8");
        for (int k = 0; k < 4; k++) step(0, 6'b0, 0, 0, 0, 0, "R8");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule